// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block is the device-side engine through which an external programmer writes and verifies the on-chip program array and the data (EEPROM) array over a three-wire serial link. The link has a serial clock, a data-in line and a data-out line. The serial clock is not used as a logic clock. The fast system clock oversamples it, and a filter accepts a level only after it has been stable for a minimum number of cycles. Every instruction is a fixed frame of four bytes, shifted most significant bit first. Input bits are taken on accepted rising edges. The output line changes only on accepted falling edges.

A control state machine has four states:

- `S_OFF`: the target reset pin is high, so the frame counters are held cleared.
- `S_DIS`: the reset pin is low and no programming-enable frame has been accepted yet.
- `S_EN`: programming mode is active.
- `S_LOCK`: a malformed enable was seen.

It has these transitions:

- *release*: `S_OFF` to `S_DIS` once the reset pin goes low.
- *enable*: `S_DIS` to `S_EN` on a valid enable frame after the power-up window has passed.
- *reject*: `S_DIS` to `S_LOCK` on a prefix frame with the wrong key.
- *resync*: any state to `S_OFF` while the reset pin is high.

In `S_EN`, completed frames issue chip-erase, data-byte write and program-byte write requests to the two byte arrays. Each of these starts a self-timed busy window. Reads return their data in the last byte of the frame.

Top module: `isp_slave`

## Requirements
- R1: Data-in bits are captured MSB first on accepted rising edges, and the data-out line changes only after accepted falling edges. During a frame, byte 0 and byte 1 return 0x00, byte 2 returns the second byte received in the same frame, and byte 3 returns read data or 0x00.
- R2: A serial-clock level lasting fewer than MIN_W system cycles is rejected. MIN_W is 4 when FAST_CLK=1 and 3 when FAST_CLK=0. A rejected glitch does not shift the frame.
- R3: In `S_DIS`, the frame 0xAC 0x53 xx xx enters `S_EN` and raises `prog_en`, provided the power-up window has passed.
- R4: An enable frame completed before PWRUP_CYC cycles have elapsed since `rst_n` release is ignored, and the block stays in `S_DIS`.
- R5: In `S_DIS`, a frame with first byte 0xAC and a second byte other than 0x53 enters `S_LOCK`. In that state no frame is decoded, including a correct enable, and reads return 0x00 until `prog_rst` is pulsed high.
- R6: While `prog_rst` is high, the block is in `S_OFF`, `prog_en` is low and the bit and byte counters are cleared. A partial frame followed by a pulse on `prog_rst` leaves the next frame correctly aligned.
- R7: In `S_EN`, the frame 0xAC 0x80 xx xx sets every byte of both arrays to 0xFF.
- R8: In `S_EN`, the frame 0xC0 hi lo d writes d to data address {hi,lo}, replacing the old value (auto-erase). The frame 0xA0 hi lo xx returns the data byte in byte 3.
- R9: In `S_EN`, the frame 0x40 hi lo d stores old AND d at program address {hi,lo}, with no erase. The frame 0x20 hi lo xx returns the program byte in byte 3.
- R10: An accepted erase or write holds `busy` high for BUSY_CYC cycles. Any erase or write frame that completes while `busy` is high is ignored.
- R11: Outside `S_EN`, write frames are ignored and read frames return 0x00 in byte 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| prog_rst | input | 1 | Target reset pin; high holds the engine off, low allows programming |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| prog_en | output | 1 | High while programming mode is active |
| busy | output | 1 | High during a self-timed erase or write |

## Verification
The bench sends whole frames with long, clean serial-clock phases. A behavioural model predicts all 32 returned bits and the mode flag for each frame, so bit order and echo placement are tested on every frame (R1). Writing 0x0F and then 0xF0 to the same address separates auto-erase overwrite (0xF0) from a plain merge (0x00). The same two-write pattern on the program array separates an AND merge from overwrite.

Short high pulses on the serial clock between frames test the filter: if a glitch were accepted, the following read would come back misaligned. Enable frames sent too early, with the wrong key, after a lock, and after a partial frame followed by a reset pulse test the four state transitions against each other. A second write sent inside the busy window shows whether the block ignores it.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_DIS  = 2'd1,
        S_EN   = 2'd2,
        S_LOCK = 2'd3
    } isp_state_e;

    localparam logic [7:0] OP_PREFIX = 8'hAC;
    localparam logic [7:0] KEY_ENTER = 8'h53;
    localparam logic [7:0] KEY_WIPE  = 8'h80;
    localparam logic [7:0] OP_WR_EE  = 8'hC0;
    localparam logic [7:0] OP_RD_EE  = 8'hA0;
    localparam logic [7:0] OP_WR_PG  = 8'h40;
    localparam logic [7:0] OP_RD_PG  = 8'h20;

endpackage

// File: rtl/isp_sck_filter.sv
module isp_sck_filter #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          meta;
    logic          smp;
    logic          lvl;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser, then a level is accepted only after MIN_W agreeing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            smp  <= 1'b0;
            lvl  <= 1'b0;
            cnt  <= '0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            meta <= sck_in;
            smp  <= meta;
            rise <= 1'b0;
            fall <= 1'b0;
            if (smp == lvl) begin
                cnt <= '0;
            end else if (cnt == CW'(MIN_W - 1)) begin
                lvl  <= smp;
                cnt  <= '0;
                rise <= smp;
                fall <= !smp;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/isp_frame.sv
module isp_frame (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        rise,
    input  logic        fall,
    input  logic        din,
    input  logic [7:0]  load_val,
    output logic [31:0] shreg,
    output logic        done_q,
    output logic [1:0]  done_idx,
    output logic        miso
);
    logic [2:0] bit_cnt;
    logic [1:0] byte_idx;
    logic [7:0] out_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            out_sr   <= '0;
            done_q   <= 1'b0;
            done_idx <= '0;
            miso     <= 1'b0;
        end else if (clr) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            out_sr   <= '0;
            done_q   <= 1'b0;
            done_idx <= '0;
        end else begin
            done_q <= 1'b0;
            if (rise) begin
                shreg   <= {shreg[30:0], din};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    done_q   <= 1'b1;
                    done_idx <= byte_idx;
                    byte_idx <= byte_idx + 1'b1;
                end
            end
            // the reply byte is loaded one cycle after a byte completes, ahead of the next fall
            if (done_q) begin
                out_sr <= load_val;
            end else if (fall) begin
                miso   <= out_sr[7];
                out_sr <= {out_sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_bytemem.sv
module isp_bytemem #(
    parameter int ADDR_W     = 6,
    parameter bit AUTO_ERASE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] merged;

    generate
        if (AUTO_ERASE) begin : g_overwrite
            assign merged = wdata;
        end else begin : g_and_merge
            assign merged = mem[waddr] & wdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= merged;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/isp_slave.sv
module isp_slave
    import isp_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PWRUP_CYC = 2000000,
    parameter int BUSY_CYC  = 4000,
    parameter bit FAST_CLK  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_rst,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic prog_en,
    output logic busy
);
    localparam int MIN_W = FAST_CLK ? 4 : 3;
    localparam int PW_W  = $clog2(PWRUP_CYC + 1);
    localparam int BZ_W  = $clog2(BUSY_CYC + 1);

    isp_state_e        state, nxt;
    logic              rst_meta, rst_s, mosi_meta, mosi_s;
    logic [PW_W-1:0]   pw_cnt;
    logic              pwr_ok;
    logic [BZ_W-1:0]   bz_cnt;
    logic              rise, fall;
    logic [31:0]       sh;
    logic              done_q;
    logic [1:0]        done_idx;
    logic              frame_done, frame_clr;
    logic [7:0]        next_out, ee_rdata, pg_rdata;
    logic              erase, ee_we, pg_we;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_meta  <= 1'b1;
            rst_s     <= 1'b1;
            mosi_meta <= 1'b0;
            mosi_s    <= 1'b0;
        end else begin
            rst_meta  <= prog_rst;
            rst_s     <= rst_meta;
            mosi_meta <= mosi;
            mosi_s    <= mosi_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_cnt <= '0;
            pwr_ok <= 1'b0;
        end else if (!pwr_ok) begin
            pw_cnt <= pw_cnt + 1'b1;
            if (pw_cnt == PW_W'(PWRUP_CYC - 1)) pwr_ok <= 1'b1;
        end
    end

    isp_sck_filter #(.MIN_W(MIN_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .sck_in(sck), .rise(rise), .fall(fall)
    );

    assign frame_clr = rst_s || (state == S_OFF);

    isp_frame u_frame (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr), .rise(rise), .fall(fall),
        .din(mosi_s), .load_val(next_out), .shreg(sh), .done_q(done_q),
        .done_idx(done_idx), .miso(miso)
    );

    assign frame_done = done_q && (done_idx == 2'd3);
    assign rd_addr    = sh[ADDR_W-1:0];
    assign wr_addr    = sh[8 +: ADDR_W];

    // reply byte for the next byte slot
    always_comb begin
        next_out = 8'h00;
        unique case (done_idx)
            2'd1: next_out = sh[7:0];
            2'd2: begin
                if (state == S_EN && sh[23:16] == OP_RD_EE)      next_out = ee_rdata;
                else if (state == S_EN && sh[23:16] == OP_RD_PG) next_out = pg_rdata;
            end
            default: next_out = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:  nxt = S_DIS;
            S_DIS: begin
                if (frame_done && sh[31:24] == OP_PREFIX) begin
                    if (sh[23:16] != KEY_ENTER) nxt = S_LOCK;
                    else if (pwr_ok)            nxt = S_EN;
                end
            end
            S_EN:   nxt = S_EN;
            S_LOCK: nxt = S_LOCK;
            default: nxt = S_OFF;
        endcase
        if (rst_s) nxt = S_OFF;
    end

    always_comb begin
        erase = 1'b0;
        ee_we = 1'b0;
        pg_we = 1'b0;
        unique case (state)
            S_EN: begin
                if (frame_done && !busy && !rst_s) begin
                    if (sh[31:24] == OP_PREFIX && sh[23:16] == KEY_WIPE) erase = 1'b1;
                    else if (sh[31:24] == OP_WR_EE)                      ee_we = 1'b1;
                    else if (sh[31:24] == OP_WR_PG)                      pg_we = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign prog_en = (state == S_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      bz_cnt <= '0;
        else if (erase || ee_we || pg_we) bz_cnt <= BZ_W'(BUSY_CYC);
        else if (bz_cnt != '0)           bz_cnt <= bz_cnt - 1'b1;
    end

    assign busy = (bz_cnt != '0);

    isp_bytemem #(.ADDR_W(ADDR_W), .AUTO_ERASE(1'b1)) u_ee (
        .clk(clk), .rst_n(rst_n), .erase(erase), .we(ee_we), .waddr(wr_addr),
        .wdata(sh[7:0]), .raddr(rd_addr), .rdata(ee_rdata)
    );

    isp_bytemem #(.ADDR_W(ADDR_W), .AUTO_ERASE(1'b0)) u_pg (
        .clk(clk), .rst_n(rst_n), .erase(erase), .we(pg_we), .waddr(wr_addr),
        .wdata(sh[7:0]), .raddr(rd_addr), .rdata(pg_rdata)
    );
endmodule

// File: rtl/isp_slave_chk.sv
module isp_slave_chk
    import isp_pkg::*;
#(
    parameter int MIN_W    = 4,
    parameter int BUSY_CYC = 4000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_s,
    input logic       pwr_ok,
    input logic       prog_en,
    input logic       busy,
    input logic       miso,
    input logic       rise,
    input logic       fall,
    input logic       mod_req,
    input isp_state_e state
);
    int gap;
    int bz_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap    <= MIN_W;
            bz_run <= 0;
        end else begin
            gap    <= (rise || fall) ? 1 : ((gap < 100000) ? gap + 1 : gap);
            bz_run <= busy ? bz_run + 1 : 0;
        end
    end

    a_r1_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(fall));

    a_r2_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |-> (gap >= MIN_W));

    a_r3_enable_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en) |-> pwr_ok);

    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCK && !rst_s) |=> (state == S_LOCK));

    a_r6_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
        rst_s |=> !prog_en);

    a_r10_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bz_run < BUSY_CYC));

    a_r10_no_modify_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |-> !busy);
endmodule

bind isp_slave isp_slave_chk #(.MIN_W(MIN_W), .BUSY_CYC(BUSY_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .pwr_ok(pwr_ok), .prog_en(prog_en),
    .busy(busy), .miso(miso), .rise(rise), .fall(fall),
    .mod_req(erase || ee_we || pg_we), .state(state)
);

// File: tb/tb_isp_slave.sv
module tb_isp_slave;
    localparam int PWRUP = 4000;
    localparam int BUSYC = 1000;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_rst = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, prog_en, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural model state
    logic [7:0] ee_m [64];
    logic [7:0] pg_m [64];
    bit m_en = 0;
    bit m_lock = 0;
    int busy_until = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isp_slave #(.ADDR_W(6), .PWRUP_CYC(PWRUP), .BUSY_CYC(BUSYC), .FAST_CLK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .sck(sck), .mosi(mosi),
        .miso(miso), .prog_en(prog_en), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (HALF - 1) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    // full frame with model prediction of returned bits and mode flag
    task automatic frame(input logic [7:0] b0, b1, b2, b3, input string tag);
        logic [31:0] rx, exp;
        logic [7:0] d;
        bit was_en, idle;
        d = 8'h00;
        if (m_en && b0 == 8'hA0) d = ee_m[b2[5:0]];
        if (m_en && b0 == 8'h20) d = pg_m[b2[5:0]];
        exp = {8'h00, 8'h00, b1, d};
        xfer({b0, b1, b2, b3}, rx);
        was_en = m_en;
        idle = (cyc >= busy_until);
        if (!m_en && !m_lock && b0 == 8'hAC) begin
            if (b1 == 8'h53) m_en = (cyc >= PWRUP);
            else m_lock = 1;
        end
        if (was_en && idle) begin
            if (b0 == 8'hAC && b1 == 8'h80) begin
                for (int k = 0; k < 64; k++) begin ee_m[k] = 8'hFF; pg_m[k] = 8'hFF; end
                busy_until = cyc + BUSYC - 40;
            end else if (b0 == 8'hC0) begin
                ee_m[b2[5:0]] = b3;
                busy_until = cyc + BUSYC - 40;
            end else if (b0 == 8'h40) begin
                pg_m[b2[5:0]] = pg_m[b2[5:0]] & b3;
                busy_until = cyc + BUSYC - 40;
            end
        end
        check(rx == exp, {tag, " R1 returned frame"}, rx, exp);
        check(prog_en == m_en, {tag, " mode flag"}, {31'd0, prog_en}, {31'd0, m_en});
    endtask

    task automatic pulse_reset();
        @(negedge clk) prog_rst = 1'b1;
        repeat (3) @(negedge clk);
        check(prog_en == 1'b0, "R6 prog_en low while reset pin high", {31'd0, prog_en}, 32'd0);
        prog_rst = 1'b0;
        m_en = 0;
        m_lock = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic glitch(input int len);
        @(negedge clk) sck = 1'b1;
        repeat (len) @(negedge clk);
        sck = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int k = 0; k < 64; k++) begin ee_m[k] = 8'hFF; pg_m[k] = 8'hFF; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R6 reset state
        check(prog_en == 1'b0 && busy == 1'b0, "R6 reset state", {30'd0, prog_en, busy}, 32'd0);
        prog_rst = 1'b0;
        repeat (6) @(negedge clk);

        // R4 enable before power-up window
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R4 early enable");
        // R11 disabled read and write
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R11 read while disabled");
        frame(8'hC0, 8'h00, 8'h05, 8'hAA, "R11 write while disabled");
        while (cyc < PWRUP + 100) @(negedge clk);

        // R3 enable after window
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R3 enable");
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R11 earlier write ignored");

        // R8 / R10 write, busy window, write during busy ignored
        frame(8'hC0, 8'h00, 8'h05, 8'h0F, "R8 write");
        check(busy == 1'b1, "R10 busy after write", {31'd0, busy}, 32'd1);
        frame(8'hC0, 8'h00, 8'h05, 8'h00, "R10 write during busy");
        wait_idle();
        frame(8'hC0, 8'h00, 8'h09, 8'h5A, "R10 write for timing");
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        check(n <= BUSYC && n >= BUSYC - 60, "R10 busy duration", n, BUSYC);
        repeat (5) @(negedge clk);
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R10 read after ignored write");

        // R8 auto-erase: 0x0F then 0xF0 reads 0xF0
        frame(8'hC0, 8'h00, 8'h05, 8'hF0, "R8 overwrite");
        wait_idle();
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R8 read overwrite");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R8 read second address");

        // R9 program AND merge
        frame(8'h40, 8'h00, 8'h07, 8'h3C, "R9 program write");
        wait_idle();
        frame(8'h40, 8'h00, 8'h07, 8'hF3, "R9 program write merge");
        wait_idle();
        frame(8'h20, 8'h00, 8'h07, 8'h00, "R9 program read");

        // R2 glitches shorter than the minimum width
        glitch(3);
        glitch(2);
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R2 read after glitches");

        // R7 chip erase
        frame(8'hAC, 8'h80, 8'h00, 8'h00, "R7 chip erase");
        wait_idle();
        frame(8'hA0, 8'h00, 8'h05, 8'h00, "R7 data array erased");
        frame(8'h20, 8'h00, 8'h07, 8'h00, "R7 program array erased");

        // R6 resync after partial frame
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = 1'b1;
            repeat (HALF - 1) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        pulse_reset();
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R6 enable after resync");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R6 aligned read");

        // R5 wrong key locks
        pulse_reset();
        frame(8'hAC, 8'h11, 8'h00, 8'h00, "R5 wrong key");
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R5 enable while locked");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R5 read while locked");
        pulse_reset();
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R5 enable after reset pulse");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule